// File: doc/BRIEF.md
# HDLC Chunked Transmit Feeder

This block feeds one outgoing frame into a 32-byte transmit FIFO, one piece at a time. A client offers a frame by giving its length in bytes. If the link is active and the block is idle, the block takes the frame and at once starts reading bytes from an external frame buffer. The buffer is addressed by byte index from zero and answers in the same cycle. Each byte read goes to the FIFO with a byte-valid strobe. After the last byte of a piece, the block issues a single-cycle command: either "more follows" or "more follows, and this ends the message".

The block then waits for the FIFO to report that its pool is free again. At that event it sends the next piece, or, when no bytes are left, pulses a completion output and returns to idle. A restart or an underrun report from the transmitter rewinds the frame to its first byte, so the next pool-free event sends the frame again from the beginning. Frame storage, HDLC framing and CRC, and the host bus lie outside this block.

Top module: `hdlc_tx_feeder`

## Requirements
- R1: After reset, `req_ready` is 1 and `fifo_wr_valid`, `cmd_valid`, `done_pulse`, `drop_pulse` and `err_pulse` are all 0.
- R2: A request taken while `req_ready` is 1, with `link_up` at 1 and a non-zero length, puts byte 0 on the FIFO strobe in the next cycle. `req_ready` then stays 0 until the completion pulse.
- R3: When more than 32 bytes remain at the start of a piece, exactly 32 bytes are written. The command that follows is 0x08, the transmit-ready bit (bit 3) alone.
- R4: When 32 or fewer bytes remain, all of them are written. The command that follows is 0x0A, the transmit-ready bit together with the message-end bit (bit 1).
- R5: The command strobe lasts one cycle. It comes in the cycle right after the last byte of a piece and is never high together with the byte strobe.
- R6: A pool-free event while waiting, with bytes left, starts the next piece in the following cycle. The piece continues at the next byte index, and each written byte equals the buffer byte at that index.
- R7: A pool-free event while waiting, with no bytes left, gives a one-cycle `done_pulse` in the next cycle. `req_ready` returns to 1 in that same cycle.
- R8: A restart or underrun event while waiting rewinds the frame to byte 0. The next pool-free event resends from byte 0, and the piece is sized and tagged from the full length.
- R9: A restart or underrun event while a piece is being written lets that piece and its command finish unchanged. The rewind then applies before the next piece.
- R10: A rewind event and a pool-free event in the same waiting cycle resend from byte 0 at once.
- R11: A request with `link_up` at 0 is discarded. `drop_pulse` is high for one cycle and the block stays idle.
- R12: A request of length 0 with `link_up` at 1 is rejected. `err_pulse` is high for one cycle and the block stays idle.
- R13: Pool-free and rewind events while idle have no effect, and a request while busy is ignored. In each case the outputs follow the same course as without the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | Link is active; frames are accepted only while 1 |
| req_valid | input | 1 | A frame is offered |
| req_len | input | LEN_W | Frame length in bytes |
| req_ready | output | 1 | Block is idle and can take a frame |
| rd_addr | output | LEN_W | Byte index read from the frame buffer |
| rd_data | input | DATA_W | Buffer byte at `rd_addr`, same cycle |
| fifo_wr_valid | output | 1 | Byte strobe into the transmit FIFO |
| fifo_wr_data | output | DATA_W | Byte written to the FIFO |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_code | output | CMD_W | Command value, 0x08 or 0x0A |
| pool_ready | input | 1 | FIFO pool free again |
| restart_ev | input | 1 | Transmitter asks for the message to be repeated |
| underrun_ev | input | 1 | Transmitter reports a data underrun |
| done_pulse | output | 1 | Frame fully sent |
| drop_pulse | output | 1 | Request discarded, link inactive |
| err_pulse | output | 1 | Request rejected, zero length |

## Verification
A wrong read index shows up on the first byte strobe after it goes wrong, as a data mismatch. A miscounted piece length shows up within one piece, as a command strobe one cycle early or late, or as a wrong end bit. A lost rewind stays hidden while the block waits. It shows at the next pool-free event, where the first byte after the event carries a non-zero index, or a completion pulse comes in place of bytes. For that reason each rewind case is followed by a pool-free event and a byte-by-byte comparison.

// File: rtl/hdlc_feed_pkg.sv
package hdlc_feed_pkg;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_SEND,
        FS_CMD,
        FS_WAIT
    } feed_state_e;

endpackage

// File: rtl/hdlc_feed_chunk.sv
// Sizes the next piece from the frame length and the current position.
module hdlc_feed_chunk #(
    parameter int LEN_W     = 11,
    parameter int CHUNK_MAX = 32,
    parameter int CHUNK_W   = $clog2(CHUNK_MAX + 1)
) (
    input  logic [LEN_W-1:0]   len,
    input  logic [LEN_W-1:0]   pos,
    output logic [CHUNK_W-1:0] chunk,
    output logic               is_last,
    output logic               is_empty
);
    localparam logic [LEN_W-1:0] CHUNK_L = LEN_W'(CHUNK_MAX);

    logic [LEN_W-1:0] rem;

    always_comb begin
        rem      = len - pos;
        is_empty = (rem == '0);
        is_last  = (rem <= CHUNK_L);
        chunk    = is_last ? rem[CHUNK_W-1:0] : CHUNK_W'(CHUNK_MAX);
    end

endmodule

// File: rtl/hdlc_feed_cmd.sv
// Builds the command written after a piece.
module hdlc_feed_cmd #(
    parameter int                 CMD_W    = 8,
    parameter logic [CMD_W-1:0]   CMD_FILL = 8'h08,
    parameter logic [CMD_W-1:0]   CMD_END  = 8'h02
) (
    input  logic             last,
    output logic [CMD_W-1:0] code
);
    always_comb begin
        code = last ? (CMD_FILL | CMD_END) : CMD_FILL;
    end

endmodule

// File: rtl/hdlc_tx_feeder.sv
module hdlc_tx_feeder
    import hdlc_feed_pkg::*;
#(
    parameter int               LEN_W     = 11,
    parameter int               DATA_W    = 8,
    parameter int               CHUNK_MAX = 32,
    parameter int               CMD_W     = 8,
    parameter logic [CMD_W-1:0] CMD_FILL  = 8'h08,
    parameter logic [CMD_W-1:0] CMD_END   = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_up,
    input  logic              req_valid,
    input  logic [LEN_W-1:0]  req_len,
    output logic              req_ready,
    output logic [LEN_W-1:0]  rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              fifo_wr_valid,
    output logic [DATA_W-1:0] fifo_wr_data,
    output logic              cmd_valid,
    output logic [CMD_W-1:0]  cmd_code,
    input  logic              pool_ready,
    input  logic              restart_ev,
    input  logic              underrun_ev,
    output logic              done_pulse,
    output logic              drop_pulse,
    output logic              err_pulse
);
    localparam int CHUNK_W = $clog2(CHUNK_MAX + 1);

    typedef struct packed {
        feed_state_e        st;
        logic [LEN_W-1:0]   len;
        logic [LEN_W-1:0]   ptr;
        logic [CHUNK_W-1:0] left;
        logic               last;
        logic               pend;
        logic               done;
        logic               drop;
        logic               err;
    } feed_regs_t;

    localparam feed_regs_t REG_RST = '{st: FS_IDLE, default: '0};

    feed_regs_t q, d;

    logic               rewind;
    logic [LEN_W-1:0]   calc_len;
    logic [LEN_W-1:0]   calc_pos;
    logic [CHUNK_W-1:0] c_chunk;
    logic               c_last;
    logic               c_empty;

    assign rewind   = restart_ev | underrun_ev;
    // Idle: size the offered frame from byte 0. Waiting: use the stored
    // frame, rewound to 0 when a rewind event arrives in the same cycle.
    assign calc_len = (q.st == FS_IDLE) ? req_len : q.len;
    assign calc_pos = ((q.st == FS_IDLE) || rewind) ? '0 : q.ptr;

    hdlc_feed_chunk #(
        .LEN_W     (LEN_W),
        .CHUNK_MAX (CHUNK_MAX),
        .CHUNK_W   (CHUNK_W)
    ) i_chunk (
        .len      (calc_len),
        .pos      (calc_pos),
        .chunk    (c_chunk),
        .is_last  (c_last),
        .is_empty (c_empty)
    );

    hdlc_feed_cmd #(
        .CMD_W    (CMD_W),
        .CMD_FILL (CMD_FILL),
        .CMD_END  (CMD_END)
    ) i_cmd (
        .last (q.last),
        .code (cmd_code)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.drop = 1'b0;
        d.err  = 1'b0;
        case (q.st)
            FS_IDLE: begin
                if (req_valid) begin
                    if (!link_up) begin
                        d.drop = 1'b1;
                    end else if (c_empty) begin
                        d.err = 1'b1;
                    end else begin
                        d.len  = req_len;
                        d.ptr  = '0;
                        d.left = c_chunk;
                        d.last = c_last;
                        d.pend = 1'b0;
                        d.st   = FS_SEND;
                    end
                end
            end
            FS_SEND: begin
                d.ptr  = q.ptr + LEN_W'(1);
                d.left = q.left - CHUNK_W'(1);
                if (rewind) begin
                    d.pend = 1'b1;
                end
                if (q.left == CHUNK_W'(1)) begin
                    d.st = FS_CMD;
                end
            end
            FS_CMD: begin
                if (q.pend || rewind) begin
                    d.ptr = '0;
                end
                d.pend = 1'b0;
                d.st   = FS_WAIT;
            end
            FS_WAIT: begin
                if (rewind) begin
                    d.ptr = '0;
                end
                if (pool_ready) begin
                    if (c_empty) begin
                        d.ptr  = '0;
                        d.done = 1'b1;
                        d.st   = FS_IDLE;
                    end else begin
                        d.left = c_chunk;
                        d.last = c_last;
                        d.st   = FS_SEND;
                    end
                end
            end
            default: d = REG_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= REG_RST;
        end else begin
            q <= d;
        end
    end

    assign req_ready     = (q.st == FS_IDLE);
    assign rd_addr       = q.ptr;
    assign fifo_wr_valid = (q.st == FS_SEND);
    assign fifo_wr_data  = rd_data;
    assign cmd_valid     = (q.st == FS_CMD);
    assign done_pulse    = q.done;
    assign drop_pulse    = q.drop;
    assign err_pulse     = q.err;

endmodule

// File: rtl/hdlc_tx_feeder_chk.sv
module hdlc_tx_feeder_chk #(
    parameter int               CHUNK_MAX = 32,
    parameter int               CMD_W     = 8,
    parameter logic [CMD_W-1:0] CMD_FILL  = 8'h08,
    parameter logic [CMD_W-1:0] CMD_END   = 8'h02
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             fifo_wr_valid,
    input logic             cmd_valid,
    input logic [CMD_W-1:0] cmd_code,
    input logic             done_pulse,
    input logic             drop_pulse,
    input logic             err_pulse
);
    localparam int RUN_W = $clog2(CHUNK_MAX + 1) + 1;

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (fifo_wr_valid) begin
            run_q <= run_q + RUN_W'(1);
        end else begin
            run_q <= '0;
        end
    end

    // R3
    chunk_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_valid |-> (run_q < RUN_W'(CHUNK_MAX)));

    // R4
    cmd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_code == CMD_FILL || cmd_code == (CMD_FILL | CMD_END)));

    // R5
    cmd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_wr_valid && cmd_valid));

    // R5
    cmd_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(fifo_wr_valid));

    // R5
    cmd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R2
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_valid |-> !req_ready);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> req_ready);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    // R11
    pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_pulse, drop_pulse, err_pulse}));

    // R12
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (req_ready && !fifo_wr_valid));

endmodule

bind hdlc_tx_feeder hdlc_tx_feeder_chk #(
    .CHUNK_MAX (CHUNK_MAX),
    .CMD_W     (CMD_W),
    .CMD_FILL  (CMD_FILL),
    .CMD_END   (CMD_END)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .fifo_wr_valid (fifo_wr_valid),
    .cmd_valid     (cmd_valid),
    .cmd_code      (cmd_code),
    .done_pulse    (done_pulse),
    .drop_pulse    (drop_pulse),
    .err_pulse     (err_pulse)
);

// File: tb/test_hdlc_tx_feeder.sv
`timescale 1ns/1ps
module test_hdlc_tx_feeder;
    localparam int LEN_W  = 11;
    localparam int DATA_W = 8;
    localparam int CMD_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              link_up = 1'b0;
    logic              req_valid = 1'b0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              req_ready;
    logic [LEN_W-1:0]  rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              fifo_wr_valid;
    logic [DATA_W-1:0] fifo_wr_data;
    logic              cmd_valid;
    logic [CMD_W-1:0]  cmd_code;
    logic              pool_ready = 1'b0;
    logic              restart_ev = 1'b0;
    logic              underrun_ev = 1'b0;
    logic              done_pulse;
    logic              drop_pulse;
    logic              err_pulse;

    always #4 clk = ~clk;

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 29 + 7) ^ (a >> 2));
    endfunction

    assign rd_data = pat(int'(rd_addr));

    hdlc_tx_feeder i_hdlc_tx_feeder (
        .clk           (clk),
        .rst_n         (rst_n),
        .link_up       (link_up),
        .req_valid     (req_valid),
        .req_len       (req_len),
        .req_ready     (req_ready),
        .rd_addr       (rd_addr),
        .rd_data       (rd_data),
        .fifo_wr_valid (fifo_wr_valid),
        .fifo_wr_data  (fifo_wr_data),
        .cmd_valid     (cmd_valid),
        .cmd_code      (cmd_code),
        .pool_ready    (pool_ready),
        .restart_ev    (restart_ev),
        .underrun_ev   (underrun_ev),
        .done_pulse    (done_pulse),
        .drop_pulse    (drop_pulse),
        .err_pulse     (err_pulse)
    );

    typedef struct {
        bit       wv;
        bit [7:0] d;
        bit       cv;
        bit [7:0] c;
        bit       conf;
        bit       drop;
        bit       err;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   cycles = 0;
    bit   finished = 0;

    bit   m_busy = 0;
    int   m_len = 0;
    int   m_ptr = 0;
    bit   m_rew = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic push_chunk();
        int n;
        exp_t e;
        n = m_len - m_ptr;
        if (n > 32) n = 32;
        for (int i = 0; i < n; i++) begin
            e = '{default: 0};
            e.wv = 1;
            e.d  = pat(m_ptr + i);
            exp_q.push_back(e);
        end
        e = '{default: 0};
        e.cv = 1;
        e.c  = (m_ptr + n == m_len) ? 8'h0A : 8'h08;
        exp_q.push_back(e);
        m_ptr += n;
    endtask

    // Behavioural reference, stepped on each rising edge.
    always @(posedge clk) begin
        exp_t e;
        cycles++;
        if (!rst_n) begin
            m_busy = 0;
            m_rew  = 0;
            exp_q.delete();
        end else if (!m_busy) begin
            if (req_valid) begin
                e = '{default: 0};
                if (!link_up) begin
                    e.drop = 1;
                    exp_q.push_back(e);
                end else if (req_len == 0) begin
                    e.err = 1;
                    exp_q.push_back(e);
                end else begin
                    m_busy = 1;
                    m_len  = int'(req_len);
                    m_ptr  = 0;
                    m_rew  = 0;
                    push_chunk();
                end
            end
        end else begin
            if (restart_ev || underrun_ev) m_rew = 1;
            if (pool_ready && exp_q.size() == 0) begin
                if (m_rew) m_ptr = 0;
                m_rew = 0;
                if (m_ptr == m_len) begin
                    e = '{default: 0};
                    e.conf = 1;
                    exp_q.push_back(e);
                    m_busy = 0;
                end else begin
                    push_chunk();
                end
            end
        end
    end

    // Cycle comparison, away from the active edge.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && !finished) begin
            e = '{default: 0};
            if (exp_q.size() != 0) e = exp_q.pop_front();
            chk(fifo_wr_valid === e.wv, "R2 byte strobe", int'(fifo_wr_valid), int'(e.wv));
            if (e.wv) chk(fifo_wr_data === e.d, "R6 byte value", int'(fifo_wr_data), int'(e.d));
            chk(cmd_valid === e.cv, "R5 command strobe", int'(cmd_valid), int'(e.cv));
            if (e.cv) chk(cmd_code === e.c, "R4 command code", int'(cmd_code), int'(e.c));
            chk(done_pulse === e.conf, "R7 done pulse", int'(done_pulse), int'(e.conf));
            chk(drop_pulse === e.drop, "R11 drop pulse", int'(drop_pulse), int'(e.drop));
            chk(err_pulse === e.err, "R12 error pulse", int'(err_pulse), int'(e.err));
            chk(req_ready === !m_busy, "R13 ready", int'(req_ready), int'(!m_busy));
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (cycles > 60000 && !finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 60000);
            summary();
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic offer(input int len);
        @(negedge clk);
        req_valid = 1;
        req_len   = LEN_W'(len);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic pool();
        @(negedge clk);
        pool_ready = 1;
        @(negedge clk);
        pool_ready = 0;
    endtask

    task automatic ev(input bit use_restart, input bit with_pool);
        @(negedge clk);
        restart_ev  = use_restart;
        underrun_ev = !use_restart;
        pool_ready  = with_pool;
        @(negedge clk);
        restart_ev  = 0;
        underrun_ev = 0;
        pool_ready  = 0;
    endtask

    task automatic quiet();
        do @(negedge clk); while (exp_q.size() != 0);
        cyc(2);
    endtask

    task automatic drain_frame();
        while (m_busy) begin
            pool();
            quiet();
        end
    endtask

    initial begin
        cyc(3);
        rst_n = 1;
        @(negedge clk);
        // R1: state right after reset
        chk(req_ready === 1'b1 && fifo_wr_valid === 1'b0 && cmd_valid === 1'b0 &&
            done_pulse === 1'b0 && drop_pulse === 1'b0 && err_pulse === 1'b0,
            "R1 reset state", int'(req_ready), 1);
        link_up = 1;

        // R2, R4: short frame in one piece, then R7 completion
        offer(5);  quiet(); drain_frame();
        // R4 boundary: exactly 32 bytes
        offer(32); quiet(); drain_frame();
        // R3 then R6: 33 bytes gives 32 + 1
        offer(33); quiet(); drain_frame();
        // R8: rewind while waiting after the first piece of 70
        offer(70); quiet();
        ev(1, 0); cyc(2);
        drain_frame();
        // R8 with underrun after the last piece, before completion
        offer(20); quiet();
        ev(0, 0); cyc(2);
        drain_frame();
        // R9: underrun in the middle of a piece
        offer(40); cyc(4);
        ev(0, 0);
        quiet(); drain_frame();
        // R9: restart in the middle of a later piece
        offer(90); quiet(); pool(); cyc(5);
        ev(1, 0);
        quiet(); drain_frame();
        // R10: rewind and pool-free together
        offer(50); quiet();
        ev(1, 1);
        quiet(); drain_frame();
        // R11: link down
        link_up = 0;
        offer(12); quiet();
        link_up = 1;
        // R12: zero length
        offer(0); quiet();
        // R13: events while idle, then a normal frame
        pool(); ev(0, 0); ev(1, 0); cyc(2);
        offer(3); quiet(); drain_frame();
        // R13: request while busy is ignored
        offer(10); cyc(2);
        offer(4);
        quiet(); drain_frame();
        // Long frame across several pieces
        offer(200); quiet(); drain_frame();
        cyc(3);
        summary();
    end

endmodule